// File: doc/BRIEF.md
# Frame-Synchronising Serial-to-Parallel Receiver

This block sits behind a demodulator. It takes one recovered data bit per bit period and finds the frame boundaries in the stream. It turns each good frame into an 8-bit word. A frame is twelve bits long, in this order on the line:
- a three-bit start code `110`;
- eight data bits, most significant first;
- one stop bit that must be `1`.

The bit clock and the data bit arrive as plain inputs that are synchronous to the system clock. A bit is taken on each falling edge of the bit clock, as seen by the system clock. Bits move through a twelve-bit window in the order they arrive. Once the window holds a full frame, it is checked on every new bit. If the start code and stop bit are not both in place, the window slips by one bit with the next arrival, and the check runs again.

When a frame matches, the data bits are copied to `word_out` and `word_valid` goes high for one bit period. The bit counter then starts over, so none of the bits of an accepted frame can be reused. The output side has no ready signal, because a radio link cannot be held back. The consumer must take the word while `word_valid` is high. `word_out` itself stays unchanged until the next accepted frame, which comes at least twelve bit periods later.

Top module: `frame_sync_deser`

## Requirements
- R1: A bit is taken only when the system clock sees `bit_clk` go from 1 to 0. The level of `bit_in` while `bit_clk` is high, or at its rising edge, has no effect.
- R2: Bits are shifted in in arrival order. The first data bit received appears on `word_out[7]` and the last on `word_out[0]`.
- R3: A frame is accepted on the bit that completes a window in which the three earliest bits are `1,1,0` in arrival order and the latest bit is `1`. On that bit, `word_out` takes the eight bits in between and `word_valid` rises.
- R4: A window is checked only when at least twelve bits have been taken since reset or since the last accepted frame. A pattern that straddles an accepted frame and fewer than twelve later bits is never accepted.
- R5: When the window does not match, it moves by one bit per new bit. A frame that follows any number of non-matching bits is accepted on its own last bit.
- R6: A window with a correct start code but a stop bit of 0 is rejected, and `word_valid` stays low.
- R7: `word_valid` rises with the `bit_clk` fall that accepts a frame and stays high until the next `bit_clk` fall, however long that takes. There is no back-pressure: nothing the consumer does can delay or repeat a word.
- R8: `word_out` holds its last accepted value until another frame is accepted.
- R9: Reset (`rst_n` low) drives `word_valid` to 0 and `word_out` to 0, and discards any partly received frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Recovered bit-rate clock; its falling edge marks a bit |
| bit_in | input | 1 | Demodulated serial data bit |
| word_out | output | 8 | Last accepted data word |
| word_valid | output | 1 | High for one bit period after a frame is accepted |

## Verification
Two things can fall on the same `bit_clk` edge: the end of one frame's valid pulse and the first bit of the next frame entering the window. The bench sends two frames back to back with no idle bits between them. On the first bit of the second frame it checks that `word_valid` has dropped while `word_out` still shows the first word. Exactly twelve bits later it checks that the second word is accepted. In a separate case, the tail of one accepted frame and four new bits together form a valid-looking window. That case shows the restarted bit count keeps the slip search from firing on bits that already belonged to an accepted frame.

// File: rtl/frame_sync_pkg.sv
package frame_sync_pkg;

  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_HDR_W  = 3;
  localparam logic [2:0]  DEF_HDR    = 3'b110;
  localparam int unsigned DEF_STOP_W = 1;

  function automatic int unsigned frame_bits(input int unsigned hdr_w,
                                             input int unsigned data_w,
                                             input int unsigned stop_w);
    return hdr_w + data_w + stop_w;
  endfunction

endpackage

// File: rtl/fs_bitclk_edge.sv
module fs_bitclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= bit_clk;
  end

  assign fall = prev_q & ~bit_clk;

  // R1
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/fs_frame_window.sv
module fs_frame_window #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic               bit_in,
  input  logic               restart,
  output logic [FRAME_W-1:0] win_next,
  output logic               full_next
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] win_q;
  logic [CNT_W-1:0]   cnt_q;

  assign win_next  = {win_q[FRAME_W-2:0], bit_in};
  assign full_next = (cnt_q >= CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (strobe) begin
      win_q <= win_next;
      if (restart)               cnt_q <= '0;
      else if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(win_q) && $stable(cnt_q)));

  // R2
  arrival_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (win_q[0] == $past(bit_in)));

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R4
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && restart) |=> (cnt_q == '0));

endmodule

// File: rtl/fs_frame_match.sv
module fs_frame_match #(
  parameter int unsigned         DATA_W  = 8,
  parameter int unsigned         HDR_W   = 3,
  parameter logic [HDR_W-1:0]    HDR_PAT = 3'b110,
  parameter int unsigned         STOP_W  = 1,
  parameter int unsigned         FRAME_W = 12
) (
  input  logic [FRAME_W-1:0] win,
  input  logic               full,
  output logic               hit,
  output logic [DATA_W-1:0]  data
);

  localparam int unsigned DATA_LSB = STOP_W;

  logic hdr_ok;
  logic stop_ok;

  assign hdr_ok = (win[FRAME_W-1 -: HDR_W] == HDR_PAT);

  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    assign data[i] = win[DATA_LSB + i];
  end

  if (STOP_W > 0) begin : g_stop
    assign stop_ok = &win[STOP_W-1:0];
  end else begin : g_nostop
    assign stop_ok = 1'b1;
  end

  assign hit = full & hdr_ok & stop_ok;

endmodule

// File: rtl/frame_sync_deser.sv
module frame_sync_deser
  import frame_sync_pkg::*;
#(
  parameter int unsigned      DATA_W  = DEF_DATA_W,
  parameter int unsigned      HDR_W   = DEF_HDR_W,
  parameter logic [HDR_W-1:0] HDR_PAT = DEF_HDR,
  parameter int unsigned      STOP_W  = DEF_STOP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word_out,
  output logic              word_valid
);

  localparam int unsigned FRAME_W = frame_bits(HDR_W, DATA_W, STOP_W);
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic               fall;
  logic [FRAME_W-1:0] win_next;
  logic               full_next;
  logic               hit;
  logic [DATA_W-1:0]  data;
  logic               accept;

  fs_bitclk_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_clk (bit_clk),
    .fall    (fall)
  );

  fs_frame_window #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (fall),
    .bit_in    (bit_in),
    .restart   (accept),
    .win_next  (win_next),
    .full_next (full_next)
  );

  fs_frame_match #(
    .DATA_W(DATA_W), .HDR_W(HDR_W), .HDR_PAT(HDR_PAT),
    .STOP_W(STOP_W), .FRAME_W(FRAME_W)
  ) u_match (
    .win  (win_next),
    .full (full_next),
    .hit  (hit),
    .data (data)
  );

  assign accept = fall & hit;

  logic [DATA_W-1:0] word_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (accept) word_q <= data;
      if (accept)    valid_q <= 1'b1;
      else if (fall) valid_q <= 1'b0;
    end
  end

  assign word_out   = word_q;
  assign word_valid = valid_q;

  // R3
  accept_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> word_valid);

  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && fall) |=> !word_valid);

  // R7
  valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !fall) |=> word_valid);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(word_out));

endmodule

// File: tb/frame_sync_deser_bench.sv
module frame_sync_deser_bench;

  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_clk = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] word_out;
  logic       word_valid;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  frame_sync_deser u_frame_sync_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_clk    (bit_clk),
    .bit_in     (bit_in),
    .word_out   (word_out),
    .word_valid (word_valid)
  );

  typedef struct packed {
    logic [3:0] lead_len;
    logic [7:0] lead;
    logic [2:0] hdr;
    logic [7:0] data;
    logic       stop;
    logic       accept;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0, 8'h00, 3'b110, 8'hA5, 1'b1, 1'b1},  // R3 R2
    '{4'd3, 8'h00, 3'b110, 8'h3C, 1'b1, 1'b1},  // R5
    '{4'd1, 8'h01, 3'b110, 8'h81, 1'b1, 1'b1},  // R5
    '{4'd4, 8'h05, 3'b110, 8'h7E, 1'b1, 1'b1},  // R5
    '{4'd2, 8'h03, 3'b110, 8'h00, 1'b1, 1'b1},  // R5
    '{4'd0, 8'h00, 3'b110, 8'hFF, 1'b0, 1'b0},  // R6
    '{4'd0, 8'h00, 3'b100, 8'h55, 1'b1, 1'b0},  // R3
    '{4'd0, 8'h00, 3'b010, 8'hC3, 1'b1, 1'b0}   // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_clk = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Wrong value on the line around the rising edge, correct value only at the fall (R1).
  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_clk = 1'b1; bit_in = ~b;
    repeat (2) @(negedge clk);
    bit_in = b;
    repeat (2) @(negedge clk);
    bit_clk = 1'b0;
    repeat (2) @(negedge clk);
    bit_in = ~b;
    @(negedge clk);
  endtask

  function automatic logic [11:0] mk_frame(input logic [2:0] h, input logic [7:0] d, input logic s);
    return {h, d, s};
  endfunction

  // Sends a frame earliest bit first; checks word_valid after every bit.
  task automatic send_frame_chk(input logic [11:0] f, input logic exp_last, input string req);
    for (int i = 11; i >= 0; i--) begin
      send_bit(f[i]);
      chk(req, word_valid, (i == 0) ? exp_last : 1'b0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R9 reset valid", word_valid, 1'b0);
    chk("R9 reset word", word_out, 8'h00);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      for (int k = int'(VECS[v].lead_len) - 1; k >= 0; k--) begin
        send_bit(VECS[v].lead[k]);
        chk("R5 lead no valid", word_valid, 1'b0);
      end
      send_frame_chk(mk_frame(VECS[v].hdr, VECS[v].data, VECS[v].stop),
                     VECS[v].accept, "R3/R5/R6 table valid");
      chk("R2/R8 table word", word_out, VECS[v].accept ? VECS[v].data : 8'h00);
    end

    // R7: valid stays high without a new fall, drops on the next one
    do_reset();
    send_frame_chk(mk_frame(3'b110, 8'h5A, 1'b1), 1'b1, "R3 accept");
    repeat (30) @(negedge clk);
    chk("R7 valid held", word_valid, 1'b1);
    chk("R2 word 5A", word_out, 8'h5A);

    // R9: reset while valid high, then partial frame across reset
    do_reset();
    chk("R9 valid cleared", word_valid, 1'b0);
    chk("R9 word cleared", word_out, 8'h00);
    begin
      logic [11:0] f = mk_frame(3'b110, 8'h96, 1'b1);
      for (int i = 11; i >= 6; i--) send_bit(f[i]);
      do_reset();
      for (int i = 5; i >= 0; i--) begin
        send_bit(f[i]);
        chk("R9 partial discarded", word_valid, 1'b0);
      end
    end
    send_frame_chk(mk_frame(3'b110, 8'hC3, 1'b1), 1'b1, "R9 after reset accept");
    chk("R9 word C3", word_out, 8'hC3);

    // Back to back: valid end and next frame's first bit on the same edge
    do_reset();
    send_frame_chk(mk_frame(3'b110, 8'h3C, 1'b1), 1'b1, "R3 first of pair");
    begin
      logic [11:0] f2 = mk_frame(3'b110, 8'h96, 1'b1);
      for (int i = 11; i >= 0; i--) begin
        send_bit(f2[i]);
        if (i == 11) begin
          chk("R7 valid dropped", word_valid, 1'b0);
          chk("R8 word held", word_out, 8'h3C);
        end else if (i == 0) begin
          chk("R3 second valid", word_valid, 1'b1);
          chk("R8 second word", word_out, 8'h96);
        end else begin
          chk("R7 no valid mid", word_valid, 1'b0);
        end
      end
    end

    // R4: tail of accepted frame + 4 new bits would look like a frame (word 08)
    do_reset();
    send_frame_chk(mk_frame(3'b110, 8'h60, 1'b1), 1'b1, "R4 setup accept");
    begin
      logic [3:0] tail = 4'b0001;
      for (int i = 3; i >= 0; i--) begin
        send_bit(tail[i]);
        chk("R4 no reuse", word_valid, 1'b0);
      end
      chk("R4 word kept", word_out, 8'h60);
      for (int i = 0; i < 8; i++) begin
        send_bit(1'b0);
        chk("R4 zeros no valid", word_valid, 1'b0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule